// File: doc/BRIEF.md
# Masked Status Interrupt Register

This block holds the event flags of a measurement chip in one 24-bit status register and gates them onto a single interrupt line through a 24-bit mask register. Both registers sit behind a simple register port: one address bus, a write strobe with write data, and a combinational read-data output. Other parts of the chip raise flags. They send one-cycle pulses for overflow, data-ready, conversion-ready, temperature-update and sag events. They hold level inputs for the three modulator-oscillation conditions and for the supply-monitor thresholds. Software clears a flag by writing a one to its bit.

Two flags do not follow the usual rules. The low-supply flag has hysteresis: once the supply has dropped below the low threshold, a clear write has no effect until the supply has been seen above the higher threshold. The command-status flag at bit 0 rests at one and drops to zero on a bad command or a failed status read. It takes part in the interrupt with inverted sense.

Top module: `stat_irq_reg`

## Requirements
- R1: After reset the status register reads 0x000001 at address 15 and the mask register reads 0x000000 at address 26. Any other address reads 0, and a write to it changes neither register.
- R2: Flag positions: bit 13 data ready, 12 conversion ready, 11 current overflow, 10 voltage overflow, 9 RMS current overflow, 8 RMS voltage overflow, 7 energy overflow, 6 temperature updated, 5 temperature oscillation, 4 current oscillation, 3 voltage oscillation, 2 sag, 1 low supply, 0 command ok. A one-cycle pulse on a flag's source sets that flag from the next clock edge on.
- R3: Writing address 15 clears each status bit (1 to 13) whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: When a set event and a clear write hit the same bit in the same cycle, the bit is 1 afterwards.
- R5: While an oscillation input (osc_v, osc_i, osc_t) stays high, its flag reads 1 again after every clear write. Once the input is low, a clear write leaves it at 0.
- R6: supply_low sets bit 1. After that, clear writes to bit 1 have no effect until supply_ok has been high for at least one cycle. After that cycle a clear write clears bit 1.
- R7: Bit 0 drops to 0 in the cycle after cmd_bad or rd_fail is high. Writing 1 to bit 0 returns it to 1. If a drop event and that write arrive together, the drop wins.
- R8: A write to address 26 stores all 24 data bits, and the mask reads back exactly that value.
- R9: irq_n is low exactly when some bit of (status with bit 0 inverted) AND mask is 1. It follows a change of status or mask with no extra cycle.
- R10: Status bits 23 to 14 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Read data for addr (combinational) |
| ev_data_rdy | input | 1 | Data-ready pulse |
| ev_conv_rdy | input | 1 | Conversion-ready pulse |
| ev_temp_upd | input | 1 | Temperature-updated pulse |
| ev_sag | input | 1 | Voltage sag pulse |
| ovf_i | input | 1 | Instantaneous current overflow pulse |
| ovf_v | input | 1 | Instantaneous voltage overflow pulse |
| ovf_irms | input | 1 | RMS current overflow pulse |
| ovf_vrms | input | 1 | RMS voltage overflow pulse |
| ovf_energy | input | 1 | Active energy overflow pulse |
| osc_v | input | 1 | Voltage channel oscillation level |
| osc_i | input | 1 | Current channel oscillation level |
| osc_t | input | 1 | Temperature channel oscillation level |
| supply_low | input | 1 | Supply is below the low threshold |
| supply_ok | input | 1 | Supply is above the high threshold |
| cmd_bad | input | 1 | Invalid command pulse |
| rd_fail | input | 1 | Failed status read pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sends a set pulse and a clear write to the same bit in one cycle. A design that gives the clear priority loses that event and reads 0. It writes ones to the low-supply bit while the supply sits between the two thresholds. A design without the hysteresis hold drops the flag too early. It writes 1 to bit 0, raises cmd_bad at the same moment, and checks the interrupt with that bit unmasked. A design that treats bit 0 like the other flags clears it to 0, or raises the interrupt while the bit rests at 1. It also writes ones to the unused bits and to stray addresses. A design that stores those bits reads them back or changes the mask.

// File: rtl/stat_irq_reg.sv
module stat_irq_reg #(
  parameter int DW        = 24,
  parameter int AW        = 5,
  parameter int STAT_ADDR = 15,
  parameter int MASK_ADDR = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ev_data_rdy,
  input  logic          ev_conv_rdy,
  input  logic          ev_temp_upd,
  input  logic          ev_sag,
  input  logic          ovf_i,
  input  logic          ovf_v,
  input  logic          ovf_irms,
  input  logic          ovf_vrms,
  input  logic          ovf_energy,
  input  logic          osc_v,
  input  logic          osc_i,
  input  logic          osc_t,
  input  logic          supply_low,
  input  logic          supply_ok,
  input  logic          cmd_bad,
  input  logic          rd_fail,
  output logic          irq_n
);
  localparam int NFLAG  = 14;
  localparam int B_CMD  = 0;
  localparam int B_LOW  = 1;

  logic [DW-1:0]    status, mask;
  logic [DW-1:0]    clr;
  logic [NFLAG-1:0] set_vec;
  logic             low_hold;

  assign clr = (wr_en && addr == AW'(STAT_ADDR)) ? wr_data : '0;

  assign set_vec = {ev_data_rdy, ev_conv_rdy, ovf_i, ovf_v, ovf_irms, ovf_vrms,
                    ovf_energy, ev_temp_upd, osc_t, osc_i, osc_v, ev_sag,
                    supply_low, cmd_bad | rd_fail};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_hold <= 1'b0;
    else if (supply_low) low_hold <= 1'b1;
    else if (supply_ok)  low_hold <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                status[B_CMD] <= 1'b1;
    else if (set_vec[B_CMD])   status[B_CMD] <= 1'b0;
    else if (clr[B_CMD])       status[B_CMD] <= 1'b1;
  end

  for (genvar i = 1; i < DW; i++) begin : g_bit
    if (i < NFLAG) begin : g_flag
      logic clr_ok;
      if (i == B_LOW) begin : g_low
        assign clr_ok = ~low_hold;
      end else begin : g_plain
        assign clr_ok = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  status[i] <= 1'b0;
        else         status[i] <= set_vec[i] | (status[i] & ~(clr[i] & clr_ok));
      end
    end else begin : g_none
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    mask <= '0;
    else if (wr_en && addr == AW'(MASK_ADDR))      mask <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (addr == AW'(STAT_ADDR))      rd_data = status;
    else if (addr == AW'(MASK_ADDR)) rd_data = mask;
  end

  assign irq_n = ~|((status ^ DW'(1)) & mask);
endmodule

module stat_irq_reg_chk #(
  parameter int DW        = 24,
  parameter int AW        = 5,
  parameter int STAT_ADDR = 15,
  parameter int MASK_ADDR = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] status,
  input logic [DW-1:0] mask,
  input logic          low_hold,
  input logic          ev_conv_rdy,
  input logic          ev_data_rdy,
  input logic          osc_v,
  input logic          supply_low,
  input logic          cmd_bad,
  input logic          rd_fail,
  input logic          irq_n
);
  logic stat_wr;
  assign stat_wr = wr_en && addr == AW'(STAT_ADDR);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_conv_rdy && stat_wr && wr_data[12]) |=> status[12]);

  // R3
  clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[13] && !ev_data_rdy) |=> !status[13]);

  // R5
  osc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_v |=> status[3]);

  // R6
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_hold && status[1]) |=> status[1]);

  // R7
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bad || rd_fail) |=> !status[0]);

  // R8
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(MASK_ADDR)) |=> mask == $past(wr_data));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[DW-1:14] == '0);
endmodule

bind stat_irq_reg stat_irq_reg_chk #(
  .DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .status(status), .mask(mask), .low_hold(low_hold),
  .ev_conv_rdy(ev_conv_rdy), .ev_data_rdy(ev_data_rdy), .osc_v(osc_v),
  .supply_low(supply_low), .cmd_bad(cmd_bad), .rd_fail(rd_fail), .irq_n(irq_n)
);

// File: tb/test_stat_irq_reg.sv
module test_stat_irq_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_STAT = 5'd15;
  localparam logic [4:0] A_MASK = 5'd26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        irq_n;
  logic [13:0] ev = '0;
  logic [13:0] lvl = '0;
  logic        rd_fail = 1'b0;
  logic        supply_ok = 1'b0;
  logic [13:0] drv;
  int checks = 0;
  int errors = 0;

  assign drv = ev | lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_irq_reg i_stat_irq_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data),
    .ev_data_rdy(drv[13]), .ev_conv_rdy(drv[12]), .ev_temp_upd(drv[6]),
    .ev_sag(drv[2]), .ovf_i(drv[11]), .ovf_v(drv[10]), .ovf_irms(drv[9]),
    .ovf_vrms(drv[8]), .ovf_energy(drv[7]), .osc_v(drv[3]), .osc_i(drv[4]),
    .osc_t(drv[5]), .supply_low(drv[1]), .supply_ok(supply_ok),
    .cmd_bad(drv[0]), .rd_fail(rd_fail), .irq_n(irq_n)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [23:0] d;
    logic [13:0] e;
    logic [23:0] exp;
  } vec_t;

  localparam vec_t VEC [0:12] = '{
    '{1'b0, 5'd0,  24'h000000, 14'h3000, 24'h003001},
    '{1'b1, 5'd15, 24'h001000, 14'h0000, 24'h002001},
    '{1'b0, 5'd0,  24'h000000, 14'h0F80, 24'h002F81},
    '{1'b1, 5'd15, 24'h000F80, 14'h0080, 24'h002081},
    '{1'b1, 5'd15, 24'hFFE000, 14'h0000, 24'h000081},
    '{1'b0, 5'd0,  24'h000000, 14'h0001, 24'h000080},
    '{1'b1, 5'd15, 24'h000001, 14'h0000, 24'h000081},
    '{1'b1, 5'd15, 24'h000001, 14'h0001, 24'h000080},
    '{1'b1, 5'd15, 24'h000081, 14'h0000, 24'h000001},
    '{1'b0, 5'd0,  24'h000000, 14'h0044, 24'h000045},
    '{1'b1, 5'd15, 24'h000044, 14'h0000, 24'h000001},
    '{1'b1, 5'd26, 24'h000044, 14'h0000, 24'h000001},
    '{1'b1, 5'd3,  24'hFFFFFF, 14'h0000, 24'h000001}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [4:0] a, input logic [23:0] d,
                      input logic [13:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; ev = e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [23:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and stray address
    rd(A_STAT, v); check("R1 status reset", v, 24'h000001);
    rd(A_MASK, v); check("R1 mask reset", v, 24'h000000);
    rd(5'd7, v);   check("R1 stray read", v, 24'h000000);
    check("R9 irq idle", {23'd0, irq_n}, 24'd1);

    // R2 R3 R4 R7 R10 vector walk
    foreach (VEC[k]) begin
      step(VEC[k].wr, VEC[k].a, VEC[k].d, VEC[k].e);
      rd(A_STAT, v);
      check($sformatf("R2/R3/R4/R7/R10 vec %0d", k), v, VEC[k].exp);
    end
    rd(A_MASK, v); check("R8 mask after vectors", v, 24'h000044);
    step(1'b1, A_MASK, 24'h000000, '0);

    // R8 mask readback all bits
    step(1'b1, A_MASK, 24'hABCDEF, '0);
    rd(A_MASK, v); check("R8 mask readback", v, 24'hABCDEF);
    step(1'b1, A_MASK, 24'h000000, '0);

    // R9 interrupt gating
    step(1'b0, 5'd0, '0, 14'h1000);
    check("R9 masked flag", {23'd0, irq_n}, 24'd1);
    @(negedge clk); wr_en = 1'b1; addr = A_MASK; wr_data = 24'h001000;
    @(posedge clk); #1; wr_en = 1'b0;
    check("R9 unmasked same cycle", {23'd0, irq_n}, 24'd0);
    step(1'b1, A_STAT, 24'h001000, '0);
    check("R9 cleared flag", {23'd0, irq_n}, 24'd1);
    step(1'b1, A_MASK, 24'h000001, '0);
    check("R9 cmd bit resting", {23'd0, irq_n}, 24'd1);
    @(negedge clk); rd_fail = 1'b1;
    @(negedge clk); rd_fail = 1'b0;
    check("R7 R9 rd_fail irq", {23'd0, irq_n}, 24'd0);
    rd(A_STAT, v); check("R7 rd_fail drop", v, 24'h000000);
    step(1'b1, A_STAT, 24'h000001, '0);
    check("R7 R9 restored irq", {23'd0, irq_n}, 24'd1);
    step(1'b1, A_MASK, 24'h000000, '0);

    // R5 oscillation level re-sets
    lvl = 14'h0008;
    step(1'b0, 5'd0, '0, '0);
    step(1'b1, A_STAT, 24'h000008, '0);
    rd(A_STAT, v); check("R5 osc held", v, 24'h000009);
    lvl = '0;
    step(1'b1, A_STAT, 24'h000008, '0);
    rd(A_STAT, v); check("R5 osc released", v, 24'h000001);

    // R6 low-supply hysteresis
    step(1'b0, 5'd0, '0, 14'h0002);
    rd(A_STAT, v); check("R6 low set", v, 24'h000003);
    step(1'b1, A_STAT, 24'h000002, '0);
    rd(A_STAT, v); check("R6 clear blocked", v, 24'h000003);
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk); supply_ok = 1'b0;
    step(1'b1, A_STAT, 24'h000002, '0);
    rd(A_STAT, v); check("R6 clear after recovery", v, 24'h000001);

    // R1 reset mid-run
    step(1'b1, A_MASK, 24'h00FFFF, 14'h2000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_STAT, v); check("R1 status after reset", v, 24'h000001);
    rd(A_MASK, v); check("R1 mask after reset", v, 24'h000000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule